// File: doc/BRIEF.md
# ECC Error Capture and Interrupt Register Block

This block sits beside a memory controller datapath and records the details of ECC events. The datapath reports correctable (CE) and uncorrectable (UE) events as single-cycle pulses on two independent channels. Each pulse carries a 34-bit address, 64 bits of data, an 8-bit syndrome and a 14-bit requester source ID. The block latches the first event of each kind and holds it until software acknowledges it. A later event that arrives while the first one is still held sets an overrun flag and leaves the held capture unchanged.

Software reaches the block through a single-cycle register port. Writes take effect on the clock edge and reads are combinational from the address. Through this port software can read the captured details, inspect and acknowledge the status flags, and gate the interrupt line through a mask register. Capture happens only while the ECC enable field is nonzero.

Top module: `ecc_err_regs`

## Requirements
- R1: After reset, the status register (0x04) reads 0, the mask register (0x0C) reads 0x8000_0000, the control register (0x00) reads 0 and irq_o is low.
- R2: Events on either channel are ignored while control bits [17:16] are 00. Any nonzero value of that field enables capture.
- R3: An enabled CE event sets status bit 0 and an enabled UE event sets status bit 2. The channel's address, data, syndrome and source ID are captured in the same edge.
- R4: Address low words are at 0x10 (CE) and 0x20 (UE) and hold address bits 31:0. The words at 0x14 (CE) and 0x24 (UE) hold address bits 33:32 in [1:0] and the syndrome in [15:8], with all other bits 0.
- R5: Captured data is read as low/high 32-bit words at 0x18/0x1C (CE) and 0x28/0x2C (UE).
- R6: The source ID register at 0x30 holds the CE source ID in [29:16] and the UE source ID in [13:0], with all other bits 0.
- R7: An event that arrives while its channel's pending bit is set leaves that channel's captured values unchanged. It sets the overrun bit instead: bit 1 for CE, bit 3 for UE.
- R8: Writing ones to the acknowledge register (0x08) clears the matching status bits, with [1:0] for CE and [3:2] for UE. Bits written as zero have no effect, and the register reads 0.
- R9: When an event arrives in the same cycle that acknowledges that channel's pending bit, the new event is captured and the pending bit stays set.
- R10: irq_o is high exactly when some status bit is set and mask bits 2 (ECC group) and 31 (global) are both 0. The other mask bits, [30:3] and [1:0], do not affect irq_o.
- R11: All 32 mask bits read back as written. Writes to the status register have no effect. Unmapped addresses read 0.
- R12: The CE and UE channels capture independently when events arrive on both in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_evt_i | input | 1 | Correctable event pulse |
| ce_addr_i | input | 34 | CE address |
| ce_data_i | input | 64 | CE data |
| ce_synd_i | input | 8 | CE syndrome |
| ce_src_i | input | 14 | CE requester source ID |
| ue_evt_i | input | 1 | Uncorrectable event pulse |
| ue_addr_i | input | 34 | UE address |
| ue_data_i | input | 64 | UE data |
| ue_synd_i | input | 8 | UE syndrome |
| ue_src_i | input | 14 | UE requester source ID |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| irq_o | output | 1 | Interrupt request |

## Verification
The collision that matters is an acknowledge write landing in the same cycle as a new event on the channel being cleared. The bench provokes this by driving the event pulse and the acknowledge write together. It then expects the new payload in the capture registers, the pending bit still set and the overrun bit cleared if it was acknowledged. A second collision is CE and UE events with different payloads in one cycle. It is judged by reading both capture sets and the shared source-ID word. A behavioural model tracks every flag and capture, and it is compared against irq_o on every clock and against register reads.

// File: rtl/ecc_err_pkg.sv
package ecc_err_pkg;
  localparam int ADDR_W    = 34;
  localparam int DATA_W    = 64;
  localparam int SYND_W    = 8;
  localparam int SRC_W     = 14;
  localparam int WORD_W    = 32;
  localparam int ADDR_HI_W = ADDR_W - WORD_W;
  localparam int DATA_HI_W = DATA_W - WORD_W;
  localparam int REG_AW    = 8;
  localparam int IDX_W     = REG_AW - 2;
  localparam int N_CHAN    = 2;

  localparam int EN_LSB       = 16;
  localparam int EN_W         = 2;
  localparam int SYND_LSB     = 8;
  localparam int SRC_CE_LSB   = 16;
  localparam int SRC_UE_LSB   = 0;
  localparam int MASK_ECC_BIT = 2;
  localparam int MASK_GLB_BIT = 31;
  localparam logic [WORD_W-1:0] MASK_RST = 32'h8000_0000;

  // word indices
  localparam logic [IDX_W-1:0] IX_CTRL = 6'd0;
  localparam logic [IDX_W-1:0] IX_STS  = 6'd1;
  localparam logic [IDX_W-1:0] IX_ACK  = 6'd2;
  localparam logic [IDX_W-1:0] IX_MASK = 6'd3;
  localparam logic [IDX_W-1:0] IX_CE0  = 6'd4;
  localparam logic [IDX_W-1:0] IX_UE0  = 6'd8;
  localparam logic [IDX_W-1:0] IX_SRC  = 6'd12;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic [SYND_W-1:0] synd;
    logic [SRC_W-1:0]  src;
  } ecc_evt_t;
endpackage

// File: rtl/ecc_err_chan.sv
module ecc_err_chan
  import ecc_err_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       evt_i,
  input  ecc_evt_t   info_i,
  input  logic [1:0] clr_i,
  output logic [1:0] sts_o,
  output ecc_evt_t   cap_o
);
  logic pend_q, ovr_q, pend_eff;
  ecc_evt_t cap_q;

  // acknowledge is applied before the incoming event is judged
  assign pend_eff = pend_q & ~clr_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      ovr_q  <= 1'b0;
      cap_q  <= '0;
    end else begin
      pend_q <= pend_eff | evt_i;
      ovr_q  <= (ovr_q & ~clr_i[1]) | (evt_i & pend_eff);
      if (evt_i && !pend_eff) cap_q <= info_i;
    end
  end

  assign sts_o = {ovr_q, pend_q};
  assign cap_o = cap_q;
endmodule

// File: rtl/ecc_err_irq.sv
module ecc_err_irq
  import ecc_err_pkg::*;
#(
  parameter int N_STS = 2 * N_CHAN
) (
  input  logic [N_STS-1:0]  sts_i,
  input  logic [WORD_W-1:0] mask_i,
  output logic              irq_o
);
  assign irq_o = (|sts_i) & ~mask_i[MASK_ECC_BIT] & ~mask_i[MASK_GLB_BIT];
endmodule

// File: rtl/ecc_err_rdmux.sv
module ecc_err_rdmux
  import ecc_err_pkg::*;
(
  input  logic [IDX_W-1:0]    idx_i,
  input  logic [EN_W-1:0]     en_i,
  input  logic [2*N_CHAN-1:0] sts_i,
  input  logic [WORD_W-1:0]   mask_i,
  input  ecc_evt_t            ce_i,
  input  ecc_evt_t            ue_i,
  output logic [WORD_W-1:0]   rdata_o
);
  function automatic logic [WORD_W-1:0] hi_word(ecc_evt_t e);
    logic [WORD_W-1:0] w;
    w = '0;
    w[ADDR_HI_W-1:0] = e.addr[ADDR_W-1:WORD_W];
    w[SYND_LSB +: SYND_W] = e.synd;
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] cap_word(ecc_evt_t e, logic [1:0] sel);
    logic [WORD_W-1:0] w;
    case (sel)
      2'd0:    w = e.addr[WORD_W-1:0];
      2'd1:    w = hi_word(e);
      2'd2:    w = e.data[WORD_W-1:0];
      default: w = e.data[DATA_W-1:WORD_W];
    endcase
    return w;
  endfunction

  always_comb begin
    rdata_o = '0;
    if (idx_i == IX_CTRL) rdata_o[EN_LSB +: EN_W] = en_i;
    else if (idx_i == IX_STS) rdata_o[2*N_CHAN-1:0] = sts_i;
    else if (idx_i == IX_MASK) rdata_o = mask_i;
    else if (idx_i[IDX_W-1:2] == IX_CE0[IDX_W-1:2]) rdata_o = cap_word(ce_i, idx_i[1:0]);
    else if (idx_i[IDX_W-1:2] == IX_UE0[IDX_W-1:2]) rdata_o = cap_word(ue_i, idx_i[1:0]);
    else if (idx_i == IX_SRC) begin
      rdata_o[SRC_CE_LSB +: SRC_W] = ce_i.src;
      rdata_o[SRC_UE_LSB +: SRC_W] = ue_i.src;
    end
  end
endmodule

// File: rtl/ecc_err_regs.sv
module ecc_err_regs
  import ecc_err_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ce_evt_i,
  input  logic [ADDR_W-1:0]  ce_addr_i,
  input  logic [DATA_W-1:0]  ce_data_i,
  input  logic [SYND_W-1:0]  ce_synd_i,
  input  logic [SRC_W-1:0]   ce_src_i,
  input  logic               ue_evt_i,
  input  logic [ADDR_W-1:0]  ue_addr_i,
  input  logic [DATA_W-1:0]  ue_data_i,
  input  logic [SYND_W-1:0]  ue_synd_i,
  input  logic [SRC_W-1:0]   ue_src_i,
  input  logic               reg_we_i,
  input  logic [REG_AW-1:0]  reg_addr_i,
  input  logic [WORD_W-1:0]  reg_wdata_i,
  output logic [WORD_W-1:0]  reg_rdata_o,
  output logic               irq_o
);
  logic [IDX_W-1:0]    idx;
  logic [EN_W-1:0]     en_q;
  logic [WORD_W-1:0]   mask_q;
  logic                en_on;
  logic [2*N_CHAN-1:0] ack_w;
  logic [2*N_CHAN-1:0] sts;
  logic [N_CHAN-1:0]   evt;
  ecc_evt_t            info [N_CHAN];
  ecc_evt_t            cap  [N_CHAN];
  logic [ADDR_W-1:0]   cap_ce_addr;

  assign idx   = reg_addr_i[REG_AW-1:2];
  assign en_on = |en_q;
  assign ack_w = (reg_we_i && idx == IX_ACK) ? reg_wdata_i[2*N_CHAN-1:0] : '0;

  assign info[0] = '{addr: ce_addr_i, data: ce_data_i, synd: ce_synd_i, src: ce_src_i};
  assign info[1] = '{addr: ue_addr_i, data: ue_data_i, synd: ue_synd_i, src: ue_src_i};
  assign evt     = {ue_evt_i, ce_evt_i} & {N_CHAN{en_on}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      mask_q <= MASK_RST;
    end else if (reg_we_i) begin
      if (idx == IX_CTRL) en_q <= reg_wdata_i[EN_LSB +: EN_W];
      if (idx == IX_MASK) mask_q <= reg_wdata_i;
    end
  end

  for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
    ecc_err_chan u_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .evt_i  (evt[c]),
      .info_i (info[c]),
      .clr_i  (ack_w[2*c +: 2]),
      .sts_o  (sts[2*c +: 2]),
      .cap_o  (cap[c])
    );
  end

  assign cap_ce_addr = cap[0].addr;

  ecc_err_irq u_irq (
    .sts_i  (sts),
    .mask_i (mask_q),
    .irq_o  (irq_o)
  );

  ecc_err_rdmux u_rdmux (
    .idx_i   (idx),
    .en_i    (en_q),
    .sts_i   (sts),
    .mask_i  (mask_q),
    .ce_i    (cap[0]),
    .ue_i    (cap[1]),
    .rdata_o (reg_rdata_o)
  );
endmodule

// File: rtl/ecc_err_regs_chk.sv
module ecc_err_regs_chk
  import ecc_err_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                ce_evt_i,
  input logic                ue_evt_i,
  input logic                irq_o,
  input logic [2*N_CHAN-1:0] sts,
  input logic [WORD_W-1:0]   mask_q,
  input logic                en_on,
  input logic [2*N_CHAN-1:0] ack_w,
  input logic [ADDR_W-1:0]   cap_ce_addr
);
  a_r10_global_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_q[MASK_GLB_BIT] |-> !irq_o);
  a_r10_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts == '0) |-> !irq_o);
  a_r2_disabled_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_on |=> $stable(cap_ce_addr));
  a_r3_ce_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_on && ce_evt_i) |=> sts[0]);
  a_r3_ue_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_on && ue_evt_i) |=> sts[2]);
  a_r7_hold_ce: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts[0] && !ack_w[0]) |=> $stable(cap_ce_addr));
  a_r8_ack_ce: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_w[0] && !(en_on && ce_evt_i)) |=> !sts[0]);
endmodule

bind ecc_err_regs ecc_err_regs_chk u_chk (.*);

// File: tb/ecc_err_regs_bench.sv
module ecc_err_regs_bench;
  import ecc_err_pkg::*;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk_i = ~clk_i;

  logic              ce_evt_i = 0, ue_evt_i = 0, reg_we_i = 0;
  ecc_evt_t          ce_p = '0, ue_p = '0;
  logic [REG_AW-1:0] reg_addr_i = '0;
  logic [WORD_W-1:0] reg_wdata_i = '0;
  logic [WORD_W-1:0] reg_rdata_o;
  logic              irq_o;

  ecc_err_regs u_ecc_err_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .ce_evt_i(ce_evt_i), .ce_addr_i(ce_p.addr), .ce_data_i(ce_p.data),
    .ce_synd_i(ce_p.synd), .ce_src_i(ce_p.src),
    .ue_evt_i(ue_evt_i), .ue_addr_i(ue_p.addr), .ue_data_i(ue_p.data),
    .ue_synd_i(ue_p.synd), .ue_src_i(ue_p.src),
    .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
  );

  // reference model
  logic     m_pend [2];
  logic     m_ovr  [2];
  ecc_evt_t m_cap  [2];
  logic [1:0]  m_en;
  logic [31:0] m_mask;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_rd(logic [7:0] a);
    int w = int'(a[7:2]);
    logic [31:0] r = '0;
    int ch = (w >= 8) ? 1 : 0;
    case (w)
      0: r[17:16] = m_en;
      1: r = {28'd0, m_ovr[1], m_pend[1], m_ovr[0], m_pend[0]};
      3: r = m_mask;
      4, 8:  r = m_cap[ch].addr[31:0];
      5, 9:  begin r[1:0] = m_cap[ch].addr[33:32]; r[15:8] = m_cap[ch].synd; end
      6, 10: r = m_cap[ch].data[31:0];
      7, 11: r = m_cap[ch].data[63:32];
      12: begin r[29:16] = m_cap[0].src; r[13:0] = m_cap[1].src; end
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic logic m_irq();
    logic any = m_pend[0] | m_ovr[0] | m_pend[1] | m_ovr[1];
    return any && !m_mask[2] && !m_mask[31];
  endfunction

  task automatic m_reset();
    for (int c = 0; c < 2; c++) begin
      m_pend[c] = 0; m_ovr[c] = 0; m_cap[c] = '0;
    end
    m_en = 0; m_mask = 32'h8000_0000;
  endtask

  // one clock: model next state from current inputs, then compare irq
  task automatic step();
    logic [3:0] ack = (reg_we_i && reg_addr_i[7:2] == 6'd2) ? reg_wdata_i[3:0] : 4'd0;
    logic ev [2];
    ecc_evt_t pl [2];
    ev[0] = ce_evt_i && (m_en != 0); ev[1] = ue_evt_i && (m_en != 0);
    pl[0] = ce_p; pl[1] = ue_p;
    @(posedge clk_i);
    for (int c = 0; c < 2; c++) begin
      logic p = m_pend[c] & ~ack[2*c];
      logic o = m_ovr[c] & ~ack[2*c+1];
      if (ev[c]) begin
        if (!p) m_cap[c] = pl[c]; else o = 1;
        p = 1;
      end
      m_pend[c] = p; m_ovr[c] = o;
    end
    if (reg_we_i && reg_addr_i[7:2] == 6'd0) m_en = reg_wdata_i[17:16];
    if (reg_we_i && reg_addr_i[7:2] == 6'd3) m_mask = reg_wdata_i;
    @(negedge clk_i);
    ce_evt_i = 0; ue_evt_i = 0; reg_we_i = 0;
    check("R10 irq", {31'd0, irq_o}, {31'd0, m_irq()});
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    reg_addr_i = a; reg_wdata_i = d; reg_we_i = 1; step();
  endtask

  task automatic rd(string tag, logic [7:0] a);
    reg_addr_i = a; #1;
    check(tag, reg_rdata_o, m_rd(a));
  endtask

  task automatic rd_lit(string tag, logic [7:0] a, logic [31:0] exp);
    reg_addr_i = a; #1;
    check(tag, reg_rdata_o, exp);
  endtask

  task automatic rd_all(string tag);
    for (int i = 0; i < 16; i++) rd(tag, 8'(i * 4));
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  ecc_evt_t pa = '{addr: 34'h2_dead_beef, data: 64'h0123_4567_89ab_cdef, synd: 8'hf4, src: 14'h2a5a};
  ecc_evt_t pb = '{addr: 34'h1_1111_2222, data: 64'hffff_0000_aaaa_5555, synd: 8'h0b, src: 14'h1234};
  ecc_evt_t pc = '{addr: 34'h3_0000_0004, data: 64'h8000_0000_0000_0001, synd: 8'h03, src: 14'h3fff};
  ecc_evt_t pd = '{addr: 34'h0_cafe_f00d, data: 64'h5a5a_5a5a_a5a5_a5a5, synd: 8'h80, src: 14'h0001};

  initial begin
    m_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1
    rd_lit("R1 status", 8'h04, 32'h0);
    rd_lit("R1 mask", 8'h0C, 32'h8000_0000);
    rd_lit("R1 ctrl", 8'h00, 32'h0);
    check("R1 irq", {31'd0, irq_o}, 32'd0);
    // R2 disabled
    ce_p = pa; ce_evt_i = 1; ue_p = pc; ue_evt_i = 1; step();
    rd_lit("R2 ignored", 8'h04, 32'h0);
    rd_all("R2");
    wr(8'h00, 32'h0001_0000);
    wr(8'h0C, 32'h0);
    rd_lit("R11 mask rw", 8'h0C, 32'h0);
    // R3 capture CE
    ce_p = pa; ce_evt_i = 1; step();
    rd_lit("R3 ce pend", 8'h04, 32'h1);
    rd_lit("R4 ce addr lo", 8'h10, 32'hdead_beef);
    rd_lit("R4 ce addr hi synd", 8'h14, 32'h0000_f402);
    rd_lit("R5 ce data lo", 8'h18, 32'h89ab_cdef);
    rd_lit("R5 ce data hi", 8'h1C, 32'h0123_4567);
    rd_lit("R6 src", 8'h30, {2'b0, 14'h2a5a, 16'h0});
    // R7 hold
    ce_p = pb; ce_evt_i = 1; step();
    rd_lit("R7 overrun", 8'h04, 32'h3);
    rd_lit("R7 held addr", 8'h10, 32'hdead_beef);
    rd_all("R7");
    // R10 / R11 masking
    wr(8'h0C, 32'h0000_0004);
    wr(8'h0C, 32'h7fff_fffb);
    rd_lit("R11 mask readback", 8'h0C, 32'h7fff_fffb);
    wr(8'h0C, 32'h8000_0000);
    wr(8'h0C, 32'h0);
    wr(8'h04, 32'hffff_ffff);
    rd_lit("R11 status ro", 8'h04, 32'h3);
    rd_lit("R11 unmapped", 8'h3C, 32'h0);
    rd_lit("R8 ack reads 0", 8'h08, 32'h0);
    // R8 ack
    wr(8'h08, 32'h0);
    rd_lit("R8 zero ack", 8'h04, 32'h3);
    wr(8'h08, 32'h2);
    rd_lit("R8 ovr only", 8'h04, 32'h1);
    // R9 ack and event together
    reg_addr_i = 8'h08; reg_wdata_i = 32'h1; reg_we_i = 1;
    ce_p = pd; ce_evt_i = 1; step();
    rd_lit("R9 pend kept", 8'h04, 32'h1);
    rd_lit("R9 new addr", 8'h10, 32'hcafe_f00d);
    rd_all("R9");
    wr(8'h08, 32'hf);
    rd_lit("R8 all clear", 8'h04, 32'h0);
    // R12 both channels, enable via 2'b10 (R2)
    wr(8'h00, 32'h0002_0000);
    ce_p = pb; ce_evt_i = 1; ue_p = pc; ue_evt_i = 1; step();
    rd_lit("R12 both pend", 8'h04, 32'h5);
    rd_lit("R12 ue addr lo", 8'h20, 32'h0000_0004);
    rd_lit("R12 ue hi synd", 8'h24, 32'h0000_0303);
    rd_lit("R12 ue data hi", 8'h2C, 32'h8000_0000);
    rd_lit("R12 src both", 8'h30, {2'b0, 14'h1234, 2'b0, 14'h3fff});
    rd_all("R12");
    ue_p = pa; ue_evt_i = 1; step();
    rd_lit("R7 ue overrun", 8'h04, 32'hd);
    wr(8'h08, 32'hc);
    rd_lit("R8 ue clear", 8'h04, 32'h1);
    wr(8'h00, 32'h0);
    ce_p = pa; ce_evt_i = 1; step();
    rd_lit("R2 off again", 8'h04, 32'h1);
    rd_all("R2 final");
    done = 1;
    finish_run();
  end
endmodule